// File: doc/BRIEF.md
# Pulse-Position Downlink Frame Decoder

This block turns the reader-to-tag pause stream into bytes. Its input is a synchronous, active-high pause indicator that an analog demodulator has already produced. Each clock cycle stands for one carrier cycle. A slot lasts `SLOT_CYC` cycles (256 by default). A pause is expected in the second half of the slot whose index carries the data.

A frame opens with a start marker made of two pauses. The spacing between those two pauses picks the coding:
- In the four-slot coding, each symbol of 4 slots carries two bits.
- In the 256-slot coding, each symbol of 256 slots carries one whole byte.

Decoded bytes leave on a one-cycle valid strobe. The final byte of a frame carries a last flag. The frame closes on an end marker, which is a pause at the very start of a symbol followed by a second pause. Any timing fault raises a one-cycle error and drops the frame. After reset the decoder ignores the line for a power-up interval.

Positions are judged only from the rising edge of each pause, with a tolerance of `JIT_TOL` cycles. In the text below, Q stands for `SLOT_CYC`/4.

Top module: `pp_frame_decoder`

## Requirements
- R1: For `POR_CYC` cycles after reset release, pauses are ignored: no byte, no error, and no frame can start.
- R2: The gap between the rising edges of the two start pauses selects the coding. A gap of 10·Q selects four-slot coding (`sel_256`=0). A gap of 14·Q selects 256-slot coding (`sel_256`=1). Any other gap returns the block to idle without an error. The first symbol begins 16·Q after the first start pause.
- R3: In 256-slot coding, a pause rising 2·Q into slot k yields the byte k. Slot 0 gives 00h and slot 255 gives FFh.
- R4: In four-slot coding, each symbol yields the slot index (0..3) as two bits. The first symbol of a byte fills bits 1:0 and the fourth symbol fills bits 7:6.
- R5: A pause edge up to `JIT_TOL` cycles early or late relative to its nominal position decodes the same as one that is on time.
- R6: A symbol with no data pause pulses `frame_err` for one cycle and aborts the frame. A byte that was decoded but not yet emitted is discarded.
- R7: Either of the following pulses `frame_err` and aborts the frame:
  - a second pause inside one symbol;
  - a pause whose edge lies outside both the data window and the end-marker window.
- R8: The end marker is a pause near the start of slot 0 of a symbol, at a byte boundary, followed by a second pause 10·Q ± `JIT_TOL` cycles later. It emits the held byte with `byte_last`=1. A marker in the middle of a byte, or a second pause that is missing or misplaced, raises `frame_err` instead.
- R9: Bytes leave in received order. Each byte except the last has `byte_last`=0. `sel_256` holds the frame's coding whenever `byte_valid` is high.
- R10: A start marker followed directly by an end marker produces no byte and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rst_n | input | 1 | Active-low reset |
| pause_i | input | 1 | Demodulated pause, high during a field gap |
| byte_valid | output | 1 | One-cycle strobe for a decoded byte |
| byte_data | output | 8 | Decoded byte |
| byte_last | output | 1 | Marks the final byte of a frame |
| frame_err | output | 1 | One-cycle strobe when a frame is aborted |
| sel_256 | output | 1 | Coding of the current frame: 1 for 256-slot, 0 for four-slot |

## Verification
The assertions take for granted that each pause is one unbroken run of high cycles and that at least one low cycle separates two pauses. Only under that condition does every pause produce exactly one rising edge. The stimulus therefore uses pauses of 12 cycles on a 64-cycle slot. Jitter is drawn within ±`JIT_TOL`, which keeps the closest pair of pauses apart: a data pause in slot 3 followed by an end marker. Between frames the bench waits longer than the start-marker timeout, so a stray leftover pause cannot pair with the next frame's opening pause.

// File: rtl/pp_frame_decoder.sv
module pp_frame_decoder #(
  parameter int SLOT_CYC = 256,
  parameter int JIT_TOL  = 8,
  parameter int POR_CYC  = 1356
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pause_i,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       byte_last,
  output logic       frame_err,
  output logic       sel_256
);
  localparam int Q    = SLOT_CYC / 4;
  localparam int SL   = $clog2(SLOT_CYC);
  localparam int PW   = SL + 8;
  localparam int CMAX = (POR_CYC > 16 * Q) ? POR_CYC : 16 * Q;
  localparam int CW   = $clog2(CMAX + 2);
  localparam logic [PW-1:0] END4   = PW'(4 * SLOT_CYC - 1);
  localparam logic [PW-1:0] END256 = PW'(256 * SLOT_CYC - 1);

  typedef enum logic [2:0] {S_POR, S_IDLE, S_SOF, S_SOFW, S_DATA, S_EOFW} st_t;

  st_t           st;
  logic          pause_q, seen, mode, pend_v;
  logic [CW-1:0] cnt;
  logic [PW-1:0] ph;
  logic [7:0]    sym, pend;
  logic [5:0]    acc;
  logic [1:0]    pairs;

  function automatic logic near(int v, int c);
    return (v >= c - JIT_TOL) && (v <= c + JIT_TOL);
  endfunction

  wire          rise    = pause_i & ~pause_q;
  wire [SL-1:0] off     = ph[SL-1:0];
  wire [7:0]    slot    = ph[PW-1:SL];
  wire          in_data = near(int'(off), 3 * Q);
  wire          in_eof  = near(int'(off), Q) && slot == 8'd0;
  wire          sym_end = ph == (mode ? END256 : END4);
  wire          full    = mode || pairs == 2'd3;
  wire [7:0]    done_b  = mode ? sym : {sym[1:0], acc};
  wire          cnt_top = int'(cnt) > 10 * Q + JIT_TOL;

  assign sel_256 = mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_POR; pause_q <= 1'b0; cnt <= '0; ph <= '0; seen <= 1'b0;
      mode <= 1'b0; pend_v <= 1'b0; pend <= '0; sym <= '0; acc <= '0;
      pairs <= '0; byte_valid <= 1'b0; byte_data <= '0; byte_last <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      pause_q    <= pause_i;
      cnt        <= cnt + 1'b1;
      byte_valid <= 1'b0;
      byte_last  <= 1'b0;
      frame_err  <= 1'b0;
      case (st)
        S_POR:  if (int'(cnt) == POR_CYC - 1) st <= S_IDLE;
        S_IDLE: if (rise) begin st <= S_SOF; cnt <= CW'(1); end
        S_SOF: begin
          if (rise) begin
            if (near(int'(cnt), 10 * Q)) begin mode <= 1'b0; st <= S_SOFW; end
            else if (near(int'(cnt), 14 * Q)) begin mode <= 1'b1; st <= S_SOFW; end
            else st <= S_IDLE;
          end else if (int'(cnt) > 14 * Q + JIT_TOL) st <= S_IDLE;
        end
        S_SOFW: begin
          if (rise) st <= S_IDLE;
          else if (int'(cnt) == 15 * Q - 1) begin
            st <= S_DATA; ph <= '0; seen <= 1'b0; pairs <= '0; pend_v <= 1'b0;
          end
        end
        S_DATA: begin
          ph <= sym_end ? '0 : ph + 1'b1;
          if (rise) begin
            if (in_data && !seen) begin
              seen <= 1'b1; sym <= slot;
            end else if (in_eof && !seen && pairs == 2'd0) begin
              st <= S_EOFW; cnt <= CW'(1);
            end else begin
              frame_err <= 1'b1; st <= S_IDLE; pend_v <= 1'b0;
            end
          end else if (sym_end) begin
            seen <= 1'b0;
            if (!seen) begin
              frame_err <= 1'b1; st <= S_IDLE; pend_v <= 1'b0;
            end else begin
              if (!mode) pairs <= pairs + 1'b1;
              if (full) begin
                if (pend_v) begin byte_valid <= 1'b1; byte_data <= pend; end
                pend <= done_b; pend_v <= 1'b1;
              end else begin
                case (pairs)
                  2'd0:    acc[1:0] <= sym[1:0];
                  2'd1:    acc[3:2] <= sym[1:0];
                  default: acc[5:4] <= sym[1:0];
                endcase
              end
            end
          end
        end
        S_EOFW: begin
          if (rise) begin
            if (near(int'(cnt), 10 * Q)) begin
              if (pend_v) begin byte_valid <= 1'b1; byte_last <= 1'b1; byte_data <= pend; end
            end else frame_err <= 1'b1;
            st <= S_IDLE; pend_v <= 1'b0;
          end else if (cnt_top) begin
            frame_err <= 1'b1; st <= S_IDLE; pend_v <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_por_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POR) |=> (!byte_valid && !frame_err));
  assert_pairs_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && mode) |-> (pairs == 2'd0));
  assert_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !byte_valid);
  assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (st == S_IDLE));
  assert_seen_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seen) |-> $past(rise));
  assert_last_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_last |-> (byte_valid && st == S_IDLE));
  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && $past(st) == S_DATA) |-> $stable(mode));
endmodule

// File: tb/tb_pp_frame_decoder.sv
module tb_pp_frame_decoder;
  localparam int S = 64, Q = 16, TOL = 8, POR = 200, PWB = 12;

  logic clk = 1'b0, rst_n = 1'b0, pause_i = 1'b0;
  logic byte_valid, byte_last, frame_err, sel_256;
  logic [7:0] byte_data;

  pp_frame_decoder #(.SLOT_CYC(S), .JIT_TOL(TOL), .POR_CYC(POR)) dut (
    .clk(clk), .rst_n(rst_n), .pause_i(pause_i), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_last(byte_last), .frame_err(frame_err),
    .sel_256(sel_256));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, mchk = 0, mfail = 0;
  int now = 0, sidx = 0, nexp = 0, got = 0, errs = 0;
  bit fm = 1'b0, finished = 1'b0;
  logic [7:0] expb [0:15];

  always @(negedge clk) begin
    if (frame_err) errs++;
    if (byte_valid) begin
      mchk++;
      if (got >= nexp) begin
        mfail++; $display("FAIL R9: extra byte actual %0h expected none", byte_data);
      end else if (byte_data !== expb[got] || byte_last !== (got == nexp - 1) || sel_256 !== fm) begin
        mfail++;
        $display("FAIL R3/R4/R9: byte %0d actual %0h/last %0b/mode %0b expected %0h/%0b/%0b",
                 got, byte_data, byte_last, sel_256, expb[got], (got == nexp - 1), fm);
      end
      got++;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: actual %0d expected %0d", req, act, exp); end
  endtask

  function automatic int jit();
    return int'($urandom_range(2 * TOL)) - TOL;
  endfunction

  function automatic int symlen();
    return fm ? 256 * S : 4 * S;
  endfunction

  task automatic pz(int t);
    int tt = (t < now) ? now + 1 : t;
    repeat (tt - now) @(negedge clk);
    pause_i = 1'b1;
    repeat (PWB) @(negedge clk);
    pause_i = 1'b0;
    now = tt + PWB;
  endtask

  task automatic sof(bit m, int j);
    fm = m; sidx = 0; now = 0; got = 0; errs = 0;
    pz(0);
    pz((m ? 14 * Q : 10 * Q) + j);
  endtask

  task automatic sym(int s, int j);
    pz(16 * Q + sidx * symlen() + s * S + 2 * Q + j);
    sidx++;
  endtask

  task automatic eof(int extra);
    int t1 = 16 * Q + sidx * symlen() + jit();
    pz(t1);
    pz(t1 + 10 * Q + extra + ((extra == 0) ? jit() : 0));
  endtask

  task automatic put_byte(logic [7:0] b);
    if (fm) sym(int'(b), jit());
    else for (int i = 0; i < 4; i++) sym(int'(b[2*i +: 2]), jit());
  endtask

  task automatic settle(int nb, int ne, string req);
    repeat (400) @(negedge clk);
    chk(got == nb, req, got, nb);
    chk(errs == ne, req, errs, ne);
  endtask

  task automatic good_frame(bit m, int n, string req);
    sof(m, jit()); nexp = n;
    for (int i = 0; i < n; i++) put_byte(expb[i]);
    eof(0);
    settle(n, 0, req);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(byte_valid == 1'b0 && frame_err == 1'b0, "R1 reset", int'(byte_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    nexp = 0; fm = 1'b0; now = 0; got = 0; errs = 0;
    pz(0); pz(10 * Q);
    settle(0, 0, "R1 power-up quiet");

    expb[0] = 8'hE1; expb[1] = 8'h00;
    good_frame(1'b0, 2, "R4 directed");

    sof(1'b0, TOL); nexp = 1; expb[0] = 8'hA5;
    for (int i = 0; i < 4; i++) sym(int'(expb[0][2*i +: 2]), (i % 2 == 0) ? TOL : -TOL);
    eof(0);
    settle(1, 0, "R5 edge jitter");

    sof(1'b0, 0); nexp = 0; eof(0);
    settle(0, 0, "R10 empty frame");

    fm = 1'b0; now = 0; got = 0; errs = 0; nexp = 0;
    pz(0); pz(12 * Q);
    settle(0, 0, "R2 bad start gap");

    sof(1'b0, 0); nexp = 0; put_byte(8'h3C); sym(1, 0);
    settle(0, 1, "R6 missing pause");

    sof(1'b0, 0); nexp = 0; sym(0, 0); sidx--; sym(2, 0);
    settle(0, 1, "R7 double pause");

    sof(1'b0, 0); nexp = 0; pz(16 * Q + S);
    settle(0, 1, "R7 off window");

    sof(1'b0, 0); nexp = 0; sym(1, 0); sym(2, 0); eof(0);
    settle(0, 1, "R8 mid-byte end");

    sof(1'b0, 0); nexp = 0; put_byte(8'h5A); eof(2 * TOL + 4);
    settle(0, 1, "R8 late end pause");

    for (int f = 0; f < 6; f++) begin
      int n = 1 + int'($urandom_range(4));
      for (int i = 0; i < n; i++) expb[i] = 8'($urandom());
      good_frame(1'b0, n, "R4/R9 random four-slot");
    end

    expb[0] = 8'h00; expb[1] = 8'hFF;
    good_frame(1'b1, 2, "R3 slot extremes");
    expb[0] = 8'($urandom());
    good_frame(1'b1, 1, "R2/R3 random 256-slot");

    finished = 1'b1;
  end

  initial begin
    for (int c = 0; c < 190000 && !finished; c++) @(posedge clk);
    if (!finished) begin fails++; $display("FAIL watchdog: actual hung expected done"); end
    $display("== %0d vectors applied, %0d miscompares ==", checks + mchk, fails + mfail);
    $finish;
  end
endmodule